// File: doc/BRIEF.md
# Registered 16-bit ALU with Condition Flags

This block performs one arithmetic, logic, shift or rotate step on two operands and produces the result together with six condition flags for a processor's flag register. Each request is sampled on a clock edge. The result, the merged flag word and an update mask come out of registers one cycle later. Operands can be handled as full 16-bit words or as 8-bit bytes. In byte mode only the low byte takes part, and every width-dependent flag is taken from bit 7.

The caller supplies the current flag word along with each request. Each operation defines which flags it writes. The flag output copies every flag outside that set unchanged from the supplied word. The mask output names the written flags, so the flag register can be loaded directly from the flag output.

Top module: `flagged_alu`

## Requirements
- R1: A request presented with `in_valid` high at a rising edge appears on `result`, `flags_out` and `flag_mask` after that edge, with `out_valid` high for exactly that one cycle.
- R2: Opcodes are 0 add, 1 subtract, 2 increment, 3 decrement, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 shift left, 9 shift right, 10 rotate left and 11 rotate right. Arithmetic results wrap modulo the operand width.
- R3: Flag bit positions are: 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign and 5 overflow. For add the carry flag is the carry out of the top bit; for subtract it is the borrow.
- R4: Zero is set when the result is 0. Sign is the top result bit. Parity is set when the low 8 result bits hold an even number of ones.
- R5: The overflow flag is set when add, subtract, increment or decrement produces a signed result outside the representable range.
- R6: The auxiliary flag is the carry (for add) or borrow (for subtract) from bit 3 into bit 4.
- R7: Increment and decrement write every flag except carry, which keeps its incoming value (mask 0x3E).
- R8: AND, OR and XOR write all six flags and clear carry, overflow and auxiliary. NOT writes no flag (mask 0).
- R9: The one-bit shifts write carry, parity, zero, sign and overflow (mask 0x3B), and carry takes the bit shifted out. For a left shift, overflow is the new top bit XOR carry. For a right shift, overflow is the old top bit, and a 0 fills the vacated bit.
- R10: The rotates write only carry (mask 0x01). Carry takes the bit that wraps around.
- R11: With `byte_mode` high, result bits 15:8 are 0 and carry, sign, overflow and zero are taken from the low byte and bit 7.
- R12: Every flag outside the mask equals the corresponding bit of `flags_in` sampled with the request.
- R13: Opcodes 12 to 15 return operand A, truncated to the selected width, with mask 0.
- R14: While reset is held, `out_valid`, `result`, `flags_out` and `flag_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operands |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B (add, subtract, logic) |
| flags_in | input | 6 | Current flag word |
| out_valid | output | 1 | Result strobe |
| result | output | 16 | Operation result |
| flags_out | output | 6 | Flag word after the operation |
| flag_mask | output | 6 | Flags written by the operation |

## Verification
The bench targets the signed and unsigned edges:
- 0x7FFF+1 and 0x8000-1 must raise overflow. A design that takes overflow from the carry would miss both.
- 0xFFFF+1 must yield zero with carry. A 17-bit result that is not truncated would get this wrong.
- 0x10-1 sets the auxiliary borrow. An adder that inverts the nibble carry wrongly would report it on the wrong side.

In byte mode the upper operand bytes are set non-zero. Flags taken from bit 15 would then show up as wrong carry, sign or zero, and a result that is not truncated would leak into the upper byte. Increment of 0xFFFF with carry already set, and NOT with an arbitrary incoming flag word, show whether preserved flags are truly copied and not recomputed. Shift and rotate vectors put 1s at both ends, so that a swapped direction or a missing wrap-around bit changes both result and carry.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;

    parameter int DATA_W = 16;
    parameter int BYTE_W = 8;
    parameter int FLAG_N = 6;

    localparam int FC = 0;
    localparam int FP = 1;
    localparam int FA = 2;
    localparam int FZ = 3;
    localparam int FS = 4;
    localparam int FO = 5;

    localparam logic [FLAG_N-1:0] MASK_ALL   = 6'h3F;
    localparam logic [FLAG_N-1:0] MASK_NOC   = 6'h3E;
    localparam logic [FLAG_N-1:0] MASK_SHIFT = 6'h3B;
    localparam logic [FLAG_N-1:0] MASK_ROT   = 6'h01;
    localparam logic [FLAG_N-1:0] MASK_NONE  = 6'h00;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic [FLAG_N-1:0] flags;
        logic [FLAG_N-1:0] mask;
    } stage_t;

endpackage

// File: rtl/fa_arith.sv
module fa_arith
    import flagged_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              aux,
    output logic              ovf
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic              use_one;
    logic              is_sub;
    logic [DATA_W-1:0] b_src;
    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   sum_w;
    logic [BYTE_W:0]   sum_n;
    logic              a_top;
    logic              bx_top;
    logic              r_top;

    always_comb begin
        use_one = (op == OP_INC) || (op == OP_DEC);
        is_sub  = (op == OP_SUB) || (op == OP_DEC);
        b_src   = use_one ? DATA_W'(1) : b;
        b_x     = is_sub ? ~b_src : b_src;
        sum_w   = {1'b0, a} + {1'b0, b_x} + (DATA_W+1)'(is_sub);
        sum_n   = {1'b0, a[BYTE_W-1:0]} + {1'b0, b_x[BYTE_W-1:0]} + (BYTE_W+1)'(is_sub);
        if (byte_mode) begin
            res    = {{HI_W{1'b0}}, sum_n[BYTE_W-1:0]};
            carry  = sum_n[BYTE_W] ^ is_sub;
            a_top  = a[BYTE_W-1];
            bx_top = b_x[BYTE_W-1];
            r_top  = sum_n[BYTE_W-1];
        end else begin
            res    = sum_w[DATA_W-1:0];
            carry  = sum_w[DATA_W] ^ is_sub;
            a_top  = a[DATA_W-1];
            bx_top = b_x[DATA_W-1];
            r_top  = sum_w[DATA_W-1];
        end
        ovf = (a_top == bx_top) && (r_top != a_top);
        aux = a[4] ^ b_src[4] ^ res[4];
    end

endmodule

// File: rtl/fa_bitwise.sv
module fa_bitwise
    import flagged_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              ovf
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] top_mask;
    logic [DATA_W-1:0] aw;
    logic              a_top;
    logic              r_top;

    always_comb begin
        wmask    = byte_mode ? {{HI_W{1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};
        top_mask = byte_mode ? (DATA_W'(1) << (BYTE_W-1)) : (DATA_W'(1) << (DATA_W-1));
        aw       = a & wmask;
        a_top    = (aw & top_mask) != '0;
        carry    = 1'b0;
        unique case (op)
            OP_AND:  res = aw & b & wmask;
            OP_OR:   res = (aw | b) & wmask;
            OP_XOR:  res = (aw ^ b) & wmask;
            OP_NOT:  res = ~aw & wmask;
            OP_SHL: begin
                res   = (aw << 1) & wmask;
                carry = a_top;
            end
            OP_SHR: begin
                res   = aw >> 1;
                carry = aw[0];
            end
            OP_ROL: begin
                res   = ((aw << 1) | DATA_W'(a_top)) & wmask;
                carry = a_top;
            end
            OP_ROR: begin
                res   = (aw >> 1) | (aw[0] ? top_mask : '0);
                carry = aw[0];
            end
            default: res = aw;
        endcase
        r_top = (res & top_mask) != '0;
        ovf   = (op == OP_SHR) ? a_top : (r_top ^ carry);
    end

endmodule

// File: rtl/fa_status.sv
module fa_status
    import flagged_alu_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  logic              byte_mode,
    output logic              zero,
    output logic              sign,
    output logic              parity
);
    always_comb begin
        if (byte_mode) begin
            zero = (res[BYTE_W-1:0] == '0);
            sign = res[BYTE_W-1];
        end else begin
            zero = (res == '0);
            sign = res[DATA_W-1];
        end
        parity = ~(^res[7:0]);
    end

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
    import flagged_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic [15:0]       opa,
    input  logic [15:0]       opb,
    input  logic [5:0]        flags_in,
    output logic              out_valid,
    output logic [15:0]       result,
    output logic [5:0]        flags_out,
    output logic [5:0]        flag_mask
);
    logic [DATA_W-1:0] ar_res;
    logic              ar_c, ar_a, ar_o;
    logic [DATA_W-1:0] bw_res;
    logic              bw_c, bw_o;
    logic [DATA_W-1:0] sel_res;
    logic              st_z, st_s, st_p;
    logic [FLAG_N-1:0] new_flags;
    logic [FLAG_N-1:0] upd;
    logic              is_arith;
    stage_t            stage_d, stage_q;

    fa_arith u_arith (
        .a(opa), .b(opb), .op(op), .byte_mode(byte_mode),
        .res(ar_res), .carry(ar_c), .aux(ar_a), .ovf(ar_o)
    );

    fa_bitwise u_bitwise (
        .a(opa), .b(opb), .op(op), .byte_mode(byte_mode),
        .res(bw_res), .carry(bw_c), .ovf(bw_o)
    );

    fa_status u_status (
        .res(sel_res), .byte_mode(byte_mode),
        .zero(st_z), .sign(st_s), .parity(st_p)
    );

    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
        sel_res  = is_arith ? ar_res : bw_res;
        new_flags     = '0;
        new_flags[FZ] = st_z;
        new_flags[FS] = st_s;
        new_flags[FP] = st_p;
        if (is_arith) begin
            new_flags[FC] = ar_c;
            new_flags[FA] = ar_a;
            new_flags[FO] = ar_o;
        end else begin
            new_flags[FC] = bw_c;
            new_flags[FO] = bw_o;
        end
        unique case (op)
            OP_ADD, OP_SUB:          upd = MASK_ALL;
            OP_INC, OP_DEC:          upd = MASK_NOC;
            OP_AND, OP_OR, OP_XOR:   begin
                upd           = MASK_ALL;
                new_flags[FC] = 1'b0;
                new_flags[FO] = 1'b0;
                new_flags[FA] = 1'b0;
            end
            OP_SHL, OP_SHR:          upd = MASK_SHIFT;
            OP_ROL, OP_ROR:          upd = MASK_ROT;
            default:                 upd = MASK_NONE;
        endcase
        stage_d.valid = in_valid;
        stage_d.res   = sel_res;
        stage_d.flags = (new_flags & upd) | (flags_in & ~upd);
        stage_d.mask  = upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.res;
    assign flags_out = stage_q.flags;
    assign flag_mask = stage_q.mask;

endmodule

// File: rtl/fa_checker.sv
module fa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic        byte_mode,
    input logic [15:0] opa,
    input logic [15:0] opb,
    input logic [5:0]  flags_in,
    input logic        out_valid,
    input logic [15:0] result,
    input logic [5:0]  flags_out,
    input logic [5:0]  flag_mask
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    keep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((flags_out ^ $past(flags_in)) & ~flag_mask) == 6'h00);

    // R11
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode) |=> result[15:8] == 8'h00);

    // R8
    not_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd7) |=> flag_mask == 6'h00);

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !byte_mode && op == 4'd0) |=> flags_out[3] == (result == 16'h0000));

    // R7
    incdec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd2 || op == 4'd3)) |=> (flag_mask == 6'h3E && flags_out[0] == $past(flags_in[0])));

    // R14
    always_comb begin
        if (!rst_n) begin
            reset_clear_chk: assert (out_valid == 1'b0 || $isunknown(out_valid));
        end
    end

endmodule

bind flagged_alu fa_checker u_chk (.*);

// File: tb/flagged_alu_test.sv
`timescale 1ns/1ps
module flagged_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [5:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [5:0]  flags_out;
    logic [5:0]  flag_mask;

    int compared = 0;
    int mismatched = 0;
    logic [27:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    flagged_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .byte_mode(byte_mode), .opa(opa), .opb(opb), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out),
        .flag_mask(flag_mask)
    );

    // expected {result, flags, mask}; flag bits: 0 C,1 P,2 A,3 Z,4 S,5 O
    function automatic logic [27:0] model(input logic [3:0] f_op, input logic [15:0] a,
                                          input logic [15:0] b, input logic bm,
                                          input logic [5:0] fin);
        int w, full, top, va, vb, r, ones;
        logic c, o, ac, z, s, p;
        logic [5:0] m, nf;
        w = bm ? 8 : 16;
        full = (1 << w) - 1;
        top = 1 << (w - 1);
        va = int'(a) & full;
        vb = int'(b) & full;
        c = 0; o = 0; ac = 0; m = 6'h00; r = va;
        case (f_op)
            4'd0, 4'd2: begin
                if (f_op == 4'd2) vb = 1;
                r = va + vb;
                c = r > full;
                r = r & full;
                o = ((va ^ r) & (vb ^ r) & top) != 0;
                ac = ((va & 15) + (vb & 15)) > 15;
                m = (f_op == 4'd0) ? 6'h3F : 6'h3E;
            end
            4'd1, 4'd3: begin
                if (f_op == 4'd3) vb = 1;
                r = (va - vb) & full;
                c = va < vb;
                o = ((va ^ vb) & (va ^ r) & top) != 0;
                ac = (va & 15) < (vb & 15);
                m = (f_op == 4'd1) ? 6'h3F : 6'h3E;
            end
            4'd4: begin r = va & vb; m = 6'h3F; end
            4'd5: begin r = va | vb; m = 6'h3F; end
            4'd6: begin r = va ^ vb; m = 6'h3F; end
            4'd7: begin r = ~va & full; m = 6'h00; end
            4'd8: begin
                c = (va & top) != 0;
                r = (va << 1) & full;
                o = ((r & top) != 0) ^ c;
                m = 6'h3B;
            end
            4'd9: begin
                c = va[0];
                r = va >> 1;
                o = (va & top) != 0;
                m = 6'h3B;
            end
            4'd10: begin
                c = (va & top) != 0;
                r = ((va << 1) | int'(c)) & full;
                m = 6'h01;
            end
            4'd11: begin
                c = va[0];
                r = (va >> 1) | (c ? top : 0);
                m = 6'h01;
            end
            default: begin r = va; m = 6'h00; end
        endcase
        z = (r == 0);
        s = (r & top) != 0;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        p = (ones % 2) == 0;
        nf = {o, s, z, ac, p, c};
        return {r[15:0], (nf & m) | (fin & ~m), m};
    endfunction

    task automatic drive(input logic [3:0] t_op, input logic [15:0] a, input logic [15:0] b,
                         input logic bm, input logic [5:0] fin, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        op        = t_op;
        opa       = a;
        opb       = b;
        byte_mode = bm;
        flags_in  = fin;
        exp_q.push_back(model(t_op, a, b, bm, fin));
        tag_q.push_back(tag);
    endtask

    // monitor: one cycle after the sampling edge the result is registered (R1)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [27:0] e, g;
            string t;
            g = {result, flags_out, flag_mask};
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R1: unexpected out_valid, got %h expected none", g);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (g !== e) begin
                    mismatched++;
                    $display("FAIL %s: got res=%h flags=%h mask=%h expected res=%h flags=%h mask=%h",
                             t, g[27:12], g[11:6], g[5:0], e[27:12], e[11:6], e[5:0]);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R14 reset state
        compared++;
        if ({out_valid, result, flags_out, flag_mask} !== 29'd0) begin
            mismatched++;
            $display("FAIL R14: got %h expected 0", {out_valid, result, flags_out, flag_mask});
        end
        rst_n = 1'b1;
        // directed corner cases
        drive(4'd0, 16'h7FFF, 16'h0001, 1'b0, 6'h00, "R5");   // signed overflow, aux
        drive(4'd0, 16'hFFFF, 16'h0001, 1'b0, 6'h00, "R3");   // carry and zero
        drive(4'd0, 16'h1234, 16'h4321, 1'b0, 6'h3F, "R2");
        drive(4'd0, 16'hAB80, 16'hCD80, 1'b1, 6'h00, "R11");  // byte carry/ovf/zero
        drive(4'd1, 16'h0000, 16'h0001, 1'b0, 6'h00, "R3");   // borrow
        drive(4'd1, 16'h8000, 16'h0001, 1'b0, 6'h00, "R5");
        drive(4'd1, 16'hFF10, 16'h0001, 1'b1, 6'h00, "R6");   // aux borrow
        drive(4'd0, 16'h000F, 16'h0001, 1'b0, 6'h00, "R6");
        drive(4'd2, 16'hFFFF, 16'h0000, 1'b0, 6'h01, "R7");   // carry kept set
        drive(4'd3, 16'h0000, 16'h0000, 1'b0, 6'h00, "R7");   // carry kept clear
        drive(4'd2, 16'h127F, 16'h0000, 1'b1, 6'h00, "R7");
        drive(4'd4, 16'hF0F0, 16'h0FF0, 1'b0, 6'h3F, "R8");
        drive(4'd5, 16'h0003, 16'h0000, 1'b0, 6'h25, "R4");
        drive(4'd6, 16'h5555, 16'h5555, 1'b0, 6'h3F, "R4");
        drive(4'd7, 16'h00FF, 16'h0000, 1'b0, 6'h2A, "R8");
        drive(4'd8, 16'h8001, 16'h0000, 1'b0, 6'h00, "R9");
        drive(4'd9, 16'h8001, 16'h0000, 1'b0, 6'h04, "R9");
        drive(4'd8, 16'hFF40, 16'h0000, 1'b1, 6'h00, "R9");
        drive(4'd10, 16'h8001, 16'h0000, 1'b0, 6'h3E, "R10");
        drive(4'd11, 16'hFF01, 16'h0000, 1'b1, 6'h00, "R10");
        drive(4'd12, 16'hBEEF, 16'h1111, 1'b0, 6'h15, "R13");
        drive(4'd15, 16'hBEEF, 16'h1111, 1'b1, 6'h2A, "R13");
        @(negedge clk) in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // pseudo-random sweep across all opcodes and modes
        lf = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a2, b2;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a2 = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b2 = lf ^ 16'h5A3C;
            drive(4'(k % 16), a2, b2, k[4], b2[5:0], "R12");
        end
        @(negedge clk) in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: nothing pending and no stray strobe
        compared++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: got pending=%0d valid=%b expected 0 and 0", exp_q.size(), out_valid);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule